// File: doc/BRIEF.md
# Link Control Word Decoder with Reset Handshake

This block sits on the receive side of a serial radio link port. It takes one 8-bit control byte at a time, together with that byte's position X inside the hyperframe (0 to 255) and a valid strobe. Every position is split into a subchannel number (X modulo 64) and a slot inside that subchannel (X divided by 64). The result is reported one cycle after the byte is accepted.

Four link-layer fields are collected while a hyperframe is received. All four sit in subchannel 2, one per slot. They are the protocol version, the HDLC rate code from the start-up byte, the layer-1 flag set and the Ethernet subchannel pointer. The fields are published together only when the last word of a complete hyperframe has been seen.

The block also runs the link reset handshake, counted in hyperframes. In the slave role it confirms a reset request from the far end, pulses a local reset, acknowledges on its uplink, raises the SDI flag and forwards the reset downstream. In the master role it holds the outgoing reset bit for the required number of hyperframes and reports each acknowledgement it receives.

Top module: `cw_link_decoder`

## Requirements
- R1: One cycle after a strobed byte, `idx_valid` is 1, `sub_ns` equals X[5:0] and `sub_xs` equals X[7:6]. A cycle with the strobe low gives `idx_valid` 0, and its byte has no effect on any field.
- R2: The byte at X=2 (subchannel 2, slot 0) is taken in full as the protocol version.
- R3: At X=66 (subchannel 2, slot 1), bits 2..0 become `hdlc_rate`: 0 none, 1 240k, 2 480k, 3 960k, 4 1920k, 5 2400k, 6 highest possible, 7 set by a higher layer. Bits 7..3 are ignored.
- R4: At X=130 (subchannel 2, slot 2), bits 4..0 become `l1_flags` (bit0 reset, bit1 remote alarm, bit2 SDI, bit3 loss of signal, bit4 loss of frame). At X=194 (slot 3), bits 5..0 become `eth_ptr`. All higher bits are ignored.
- R5: Field outputs change only after the word at X=255 of a hyperframe whose word X=0 was also received since reset. `fields_valid` goes to 1 at the first such publish and stays 1. A hyperframe entered part-way publishes nothing.
- R6: In the slave role, the reset bit seen in 2 consecutive complete hyperframes produces exactly one one-cycle `local_reset` pulse. A bit seen in a single hyperframe does nothing, and a bit that stays set does not retrigger.
- R7: In the slave role, `tx_reset_bit` is 1 from the pulse until 5 more hyperframe ends have passed.
- R8: In the slave role, `tx_sdi_bit` and `fwd_reset_bit` are 1 from the pulse until 10 more hyperframe ends have passed.
- R9: In the master role, a `reset_req` cycle sets `tx_reset_bit` from the next cycle until 10 hyperframe ends have passed. `local_reset` never pulses in this role.
- R10: In the master role, `ack_rcvd` pulses for one cycle at the end of each hyperframe whose received reset bit is 1. It never pulses in the slave role.
- R11: During and right after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| role_master | input | 1 | 1 = master role, 0 = slave role; change only during reset |
| reset_req | input | 1 | Master role: start a downlink reset request |
| cw_valid | input | 1 | Control byte strobe |
| cw_index | input | 8 | Position X of the byte in the hyperframe |
| cw_byte | input | 8 | Control byte |
| idx_valid | output | 1 | Split index valid |
| sub_ns | output | 6 | Subchannel number |
| sub_xs | output | 2 | Slot inside the subchannel |
| prot_ver | output | 8 | Published protocol version |
| hdlc_rate | output | 3 | Published HDLC rate code |
| l1_flags | output | 5 | Published layer-1 flags |
| eth_ptr | output | 6 | Published Ethernet start subchannel |
| fields_valid | output | 1 | At least one complete hyperframe published |
| tx_reset_bit | output | 1 | Reset bit to send on the outgoing link |
| tx_sdi_bit | output | 1 | SDI bit to send (slave in reset) |
| fwd_reset_bit | output | 1 | Reset to forward on downstream master ports |
| local_reset | output | 1 | One-cycle local reset pulse |
| ack_rcvd | output | 1 | Master role: acknowledgement seen this hyperframe |

## Verification
Index splitting is tried at several positions whose subchannel and slot differ in both parts. This catches a swapped or misaligned split. Field bytes are sent with their reserved bits set, so a missing mask shows up. A version is sent mid-hyperframe and read before the last word, which tells publish-at-end apart from update-on-arrival. A partial hyperframe shows whether the start is tracked, and an unstrobed byte at a field position shows whether the strobe is honoured. The handshake is driven with a single-hyperframe bit, two consecutive bits, and a bit that stays set. The counters are then read one hyperframe before and one after each expiry, which separates off-by-one lengths and confirms that the slave role never retriggers.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

   // slot numbers inside the field subchannel
   localparam int SLOT_VER   = 0;
   localparam int SLOT_START = 1;
   localparam int SLOT_FLAGS = 2;
   localparam int SLOT_PTR   = 3;
   localparam int NUM_SLOTS  = 4;

   // meaningful (non-reserved) width of each field slot
   function automatic int slot_width(input int slot);
      case (slot)
         SLOT_VER:   return 8;
         SLOT_START: return 3;
         SLOT_FLAGS: return 5;
         default:    return 6;
      endcase
   endfunction

   typedef struct packed {
      logic [7:0] ver;
      logic [2:0] rate;
      logic [4:0] flags;
      logic [5:0] ptr;
   } link_fields_t;

endpackage

// File: rtl/cwd_index_split.sv
module cwd_index_split #(
   parameter int NS_W = 6,
   parameter int XS_W = 2,
   parameter int CW_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [NS_W+XS_W-1:0] in_index,
   input  logic [CW_W-1:0]      in_byte,
   output logic                 st_valid,
   output logic [NS_W-1:0]      st_ns,
   output logic [XS_W-1:0]      st_xs,
   output logic [CW_W-1:0]      st_byte
);
   // X = Ns + 2^NS_W * Xs: low bits give the subchannel, high bits the slot
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_valid <= 1'b0;
         st_ns    <= '0;
         st_xs    <= '0;
         st_byte  <= '0;
      end else begin
         st_valid <= in_valid;
         if (in_valid) begin
            st_ns   <= in_index[NS_W-1:0];
            st_xs   <= in_index[NS_W+XS_W-1:NS_W];
            st_byte <= in_byte;
         end
      end
   end
endmodule

// File: rtl/cwd_field_latch.sv
module cwd_field_latch
   import cwd_pkg::*;
#(
   parameter int NS_W     = 6,
   parameter int XS_W     = 2,
   parameter int CW_W     = 8,
   parameter int FIELD_NS = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            st_valid,
   input  logic [NS_W-1:0] st_ns,
   input  logic [XS_W-1:0] st_xs,
   input  logic [CW_W-1:0] st_byte,
   output link_fields_t    fields,
   output logic            fields_valid,
   output logic            hf_end,
   output logic            rx_rst_bit
);
   logic hf_started;
   logic field_word;

   assign field_word = st_valid && (st_ns == NS_W'(FIELD_NS));

   // one shadow register per slot, holding only its non-reserved bits
   for (genvar s = 0; s < NUM_SLOTS; s++) begin : gen_slot
      localparam int SW = slot_width(s);
      logic [SW-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '0;
         else if (field_word && st_xs == XS_W'(s))
            q <= st_byte[SW-1:0];
      end
   end

   // a hyperframe counts only if its first word was seen
   always_ff @(posedge clk) begin
      if (!rst_n)
         hf_started <= 1'b0;
      else if (st_valid && st_ns == '0 && st_xs == '0)
         hf_started <= 1'b1;
   end

   assign hf_end     = st_valid && (&st_ns) && (&st_xs) && hf_started;
   assign rx_rst_bit = gen_slot[SLOT_FLAGS].q[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fields       <= '0;
         fields_valid <= 1'b0;
      end else if (hf_end) begin
         fields.ver   <= gen_slot[SLOT_VER].q;
         fields.rate  <= gen_slot[SLOT_START].q;
         fields.flags <= gen_slot[SLOT_FLAGS].q;
         fields.ptr   <= gen_slot[SLOT_PTR].q;
         fields_valid <= 1'b1;
      end
   end
endmodule

// File: rtl/cwd_reset_hs.sv
module cwd_reset_hs #(
   parameter int REQ_HF = 10,
   parameter int ACK_HF = 5,
   parameter int FWD_HF = 10,
   parameter int RUN_HF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic role_master,
   input  logic reset_req,
   input  logic hf_end,
   input  logic rx_rst_bit,
   output logic tx_reset_bit,
   output logic tx_sdi_bit,
   output logic fwd_reset_bit,
   output logic local_reset,
   output logic ack_rcvd
);
   localparam int REQ_W = $clog2(REQ_HF + 1);
   localparam int ACK_W = $clog2(ACK_HF + 1);
   localparam int FWD_W = $clog2(FWD_HF + 1);
   localparam int RUN_W = $clog2(RUN_HF + 1);

   logic [REQ_W-1:0] req_cnt;
   logic [ACK_W-1:0] ack_cnt;
   logic [FWD_W-1:0] fwd_cnt;
   logic [RUN_W-1:0] run_cnt;
   logic             confirm;

   // slave: the notification becomes valid on the RUN_HF-th consecutive bit
   assign confirm = !role_master && hf_end && rx_rst_bit &&
                    (run_cnt == RUN_W'(RUN_HF - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_cnt     <= '0;
         ack_cnt     <= '0;
         fwd_cnt     <= '0;
         run_cnt     <= '0;
         local_reset <= 1'b0;
         ack_rcvd    <= 1'b0;
      end else begin
         local_reset <= confirm;
         ack_rcvd    <= role_master && hf_end && rx_rst_bit;
         if (role_master) begin
            ack_cnt <= '0;
            fwd_cnt <= '0;
            run_cnt <= '0;
            if (reset_req)
               req_cnt <= REQ_W'(REQ_HF);
            else if (hf_end && req_cnt != '0)
               req_cnt <= req_cnt - 1'b1;
         end else begin
            req_cnt <= '0;
            if (hf_end) begin
               if (!rx_rst_bit)
                  run_cnt <= '0;
               else if (run_cnt < RUN_W'(RUN_HF))
                  run_cnt <= run_cnt + 1'b1;
            end
            if (confirm) begin
               ack_cnt <= ACK_W'(ACK_HF);
               fwd_cnt <= FWD_W'(FWD_HF);
            end else if (hf_end) begin
               if (ack_cnt != '0) ack_cnt <= ack_cnt - 1'b1;
               if (fwd_cnt != '0) fwd_cnt <= fwd_cnt - 1'b1;
            end
         end
      end
   end

   assign tx_reset_bit  = role_master ? (req_cnt != '0) : (ack_cnt != '0);
   assign tx_sdi_bit    = !role_master && (fwd_cnt != '0);
   assign fwd_reset_bit = !role_master && (fwd_cnt != '0);
endmodule

// File: rtl/cw_link_decoder.sv
module cw_link_decoder
   import cwd_pkg::*;
#(
   parameter int NS_W     = 6,
   parameter int XS_W     = 2,
   parameter int CW_W     = 8,
   parameter int FIELD_NS = 2,
   parameter int REQ_HF   = 10,
   parameter int ACK_HF   = 5,
   parameter int FWD_HF   = 10,
   parameter int RUN_HF   = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 role_master,
   input  logic                 reset_req,
   input  logic                 cw_valid,
   input  logic [NS_W+XS_W-1:0] cw_index,
   input  logic [CW_W-1:0]      cw_byte,
   output logic                 idx_valid,
   output logic [NS_W-1:0]      sub_ns,
   output logic [XS_W-1:0]      sub_xs,
   output logic [7:0]           prot_ver,
   output logic [2:0]           hdlc_rate,
   output logic [4:0]           l1_flags,
   output logic [5:0]           eth_ptr,
   output logic                 fields_valid,
   output logic                 tx_reset_bit,
   output logic                 tx_sdi_bit,
   output logic                 fwd_reset_bit,
   output logic                 local_reset,
   output logic                 ack_rcvd
);
   if (CW_W != 8) begin : gen_bad_cw
      $error("control word width must be 8");
   end
   if (XS_W != 2) begin : gen_bad_xs
      $error("four slots per subchannel are required");
   end
   if (FIELD_NS < 0 || FIELD_NS >= (1 << NS_W)) begin : gen_bad_field
      $error("field subchannel out of range");
   end
   if (REQ_HF < 1 || ACK_HF < 1 || FWD_HF < 1 || RUN_HF < 1) begin : gen_bad_cnt
      $error("hyperframe counts must be at least 1");
   end

   logic            st_valid;
   logic [NS_W-1:0] st_ns;
   logic [XS_W-1:0] st_xs;
   logic [CW_W-1:0] st_byte;
   link_fields_t    fields;
   logic            hf_end;
   logic            rx_rst_bit;

   cwd_index_split #(.NS_W(NS_W), .XS_W(XS_W), .CW_W(CW_W)) i_split (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (cw_valid),
      .in_index (cw_index),
      .in_byte  (cw_byte),
      .st_valid (st_valid),
      .st_ns    (st_ns),
      .st_xs    (st_xs),
      .st_byte  (st_byte)
   );

   cwd_field_latch #(.NS_W(NS_W), .XS_W(XS_W), .CW_W(CW_W), .FIELD_NS(FIELD_NS)) i_latch (
      .clk          (clk),
      .rst_n        (rst_n),
      .st_valid     (st_valid),
      .st_ns        (st_ns),
      .st_xs        (st_xs),
      .st_byte      (st_byte),
      .fields       (fields),
      .fields_valid (fields_valid),
      .hf_end       (hf_end),
      .rx_rst_bit   (rx_rst_bit)
   );

   cwd_reset_hs #(.REQ_HF(REQ_HF), .ACK_HF(ACK_HF), .FWD_HF(FWD_HF), .RUN_HF(RUN_HF)) i_hs (
      .clk           (clk),
      .rst_n         (rst_n),
      .role_master   (role_master),
      .reset_req     (reset_req),
      .hf_end        (hf_end),
      .rx_rst_bit    (rx_rst_bit),
      .tx_reset_bit  (tx_reset_bit),
      .tx_sdi_bit    (tx_sdi_bit),
      .fwd_reset_bit (fwd_reset_bit),
      .local_reset   (local_reset),
      .ack_rcvd      (ack_rcvd)
   );

   assign idx_valid = st_valid;
   assign sub_ns    = st_ns;
   assign sub_xs    = st_xs;
   assign prot_ver  = fields.ver;
   assign hdlc_rate = fields.rate;
   assign l1_flags  = fields.flags;
   assign eth_ptr   = fields.ptr;
endmodule

// File: rtl/cw_link_decoder_chk.sv
module cw_link_decoder_chk #(
   parameter int NS_W = 6,
   parameter int XS_W = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 role_master,
   input logic                 cw_valid,
   input logic [NS_W+XS_W-1:0] cw_index,
   input logic                 idx_valid,
   input logic [NS_W-1:0]      sub_ns,
   input logic [XS_W-1:0]      sub_xs,
   input logic [7:0]           prot_ver,
   input logic [2:0]           hdlc_rate,
   input logic [4:0]           l1_flags,
   input logic [5:0]           eth_ptr,
   input logic                 fields_valid,
   input logic                 tx_reset_bit,
   input logic                 tx_sdi_bit,
   input logic                 fwd_reset_bit,
   input logic                 local_reset,
   input logic                 ack_rcvd
);
   a_r1_split: assert property (@(posedge clk) disable iff (!rst_n)
      cw_valid |=> idx_valid && sub_ns == $past(cw_index[NS_W-1:0]) &&
                   sub_xs == $past(cw_index[NS_W+XS_W-1:NS_W]));

   a_r5_publish_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      !(idx_valid && (&sub_ns) && (&sub_xs)) |=>
         $stable(prot_ver) && $stable(hdlc_rate) && $stable(l1_flags) &&
         $stable(eth_ptr) && $stable(fields_valid));

   a_r5_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      fields_valid |=> fields_valid);

   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      local_reset |=> !local_reset);

   a_r8_pulse_starts_ack: assert property (@(posedge clk) disable iff (!rst_n)
      local_reset |-> tx_reset_bit && tx_sdi_bit && fwd_reset_bit);

   a_r9_master_no_local: assert property (@(posedge clk) disable iff (!rst_n)
      role_master |-> !local_reset && !tx_sdi_bit && !fwd_reset_bit);

   a_r10_ack_master_only: assert property (@(posedge clk) disable iff (!rst_n)
      !role_master |-> !ack_rcvd);
endmodule

bind cw_link_decoder cw_link_decoder_chk #(.NS_W(NS_W), .XS_W(XS_W)) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .role_master   (role_master),
   .cw_valid      (cw_valid),
   .cw_index      (cw_index),
   .idx_valid     (idx_valid),
   .sub_ns        (sub_ns),
   .sub_xs        (sub_xs),
   .prot_ver      (prot_ver),
   .hdlc_rate     (hdlc_rate),
   .l1_flags      (l1_flags),
   .eth_ptr       (eth_ptr),
   .fields_valid  (fields_valid),
   .tx_reset_bit  (tx_reset_bit),
   .tx_sdi_bit    (tx_sdi_bit),
   .fwd_reset_bit (fwd_reset_bit),
   .local_reset   (local_reset),
   .ack_rcvd      (ack_rcvd)
);

// File: tb/test_cw_link_decoder.sv
module test_cw_link_decoder;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       role_master = 1'b0;
   logic       reset_req = 1'b0;
   logic       cw_valid = 1'b0;
   logic [7:0] cw_index = '0;
   logic [7:0] cw_byte = '0;
   logic       idx_valid;
   logic [5:0] sub_ns;
   logic [1:0] sub_xs;
   logic [7:0] prot_ver;
   logic [2:0] hdlc_rate;
   logic [4:0] l1_flags;
   logic [5:0] eth_ptr;
   logic       fields_valid, tx_reset_bit, tx_sdi_bit, fwd_reset_bit;
   logic       local_reset, ack_rcvd;

   int tests = 0;
   int fails = 0;
   int lr_count = 0;
   int ack_count = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   cw_link_decoder i_cw_link_decoder (
      .clk(clk), .rst_n(rst_n), .role_master(role_master), .reset_req(reset_req),
      .cw_valid(cw_valid), .cw_index(cw_index), .cw_byte(cw_byte),
      .idx_valid(idx_valid), .sub_ns(sub_ns), .sub_xs(sub_xs),
      .prot_ver(prot_ver), .hdlc_rate(hdlc_rate), .l1_flags(l1_flags), .eth_ptr(eth_ptr),
      .fields_valid(fields_valid), .tx_reset_bit(tx_reset_bit), .tx_sdi_bit(tx_sdi_bit),
      .fwd_reset_bit(fwd_reset_bit), .local_reset(local_reset), .ack_rcvd(ack_rcvd)
   );

   always @(negedge clk) begin
      if (local_reset) lr_count++;
      if (ack_rcvd) ack_count++;
   end

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic put(input int x, input logic [7:0] b);
      cw_valid = 1'b1;
      cw_index = 8'(x);
      cw_byte  = b;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      cw_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // words first..last; field positions get given bytes, others a pattern
   task automatic send_range(input int first, input int last, input logic [7:0] ver,
                             input logic [7:0] st, input logic [7:0] fl, input logic [7:0] pt);
      for (int x = first; x <= last; x++) begin
         case (x)
            2:       put(x, ver);
            66:      put(x, st);
            130:     put(x, fl);
            194:     put(x, pt);
            default: put(x, 8'(x) ^ 8'h5A);
         endcase
      end
   endtask

   task automatic send_hf(input logic [7:0] fl);
      send_range(0, 255, 8'h01, 8'h01, fl, 8'h10);
      idle(3);
   endtask

   task automatic do_reset(input logic master);
      rst_n = 1'b0;
      cw_valid = 1'b0;
      role_master = master;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      lr_count = 0;
      ack_count = 0;
   endtask

   task automatic t_reset_state();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R11 idx_valid", idx_valid, 0);
      check("R11 fields", {prot_ver, hdlc_rate, l1_flags, eth_ptr, fields_valid}, 0);
      check("R11 handshake", {tx_reset_bit, tx_sdi_bit, fwd_reset_bit, local_reset, ack_rcvd}, 0);
      do_reset(1'b0);
      check("R11 after release", {idx_valid, fields_valid, tx_reset_bit, local_reset}, 0);
   endtask

   task automatic t_split();
      put(194, 8'h00);
      check("R1 ns at 194", sub_ns, 2);
      check("R1 xs at 194", sub_xs, 3);
      check("R1 valid", idx_valid, 1);
      put(133, 8'h00);
      check("R1 ns/xs at 133", {sub_xs, sub_ns}, {2'd2, 6'd5});
      put(63, 8'h00);
      check("R1 ns/xs at 63", {sub_xs, sub_ns}, {2'd0, 6'd63});
      idle(1);
      check("R1 no strobe", idx_valid, 0);
   endtask

   task automatic t_fields();
      // partial hyperframe: no publish
      send_range(100, 255, 8'h07, 8'h07, 8'h1F, 8'h3F);
      idle(3);
      check("R5 partial no valid", fields_valid, 0);
      check("R5 partial no publish", prot_ver, 0);
      // full hyperframe with reserved bits set
      send_range(0, 255, 8'h02, 8'hFB, 8'hFA, 8'hE5);
      idle(3);
      check("R5 valid after full", fields_valid, 1);
      check("R2 version", prot_ver, 2);
      check("R3 rate masked", hdlc_rate, 3);
      check("R4 flags masked", l1_flags, 5'h1A);
      check("R4 pointer masked", eth_ptr, 6'h25);
      // second hyperframe, check mid-way
      send_range(0, 150, 8'h01, 8'h06, 8'h14, 8'h3F);
      check("R5 mid-frame version held", prot_ver, 2);
      check("R5 mid-frame rate held", hdlc_rate, 3);
      cw_valid = 1'b0; cw_index = 8'd2; cw_byte = 8'h33;
      @(negedge clk);
      send_range(151, 255, 8'h01, 8'h06, 8'h14, 8'h3F);
      idle(3);
      check("R2 version updated, unstrobed ignored (R1)", prot_ver, 1);
      check("R3 rate 6", hdlc_rate, 6);
      check("R4 flags", l1_flags, 5'h14);
      check("R4 pointer", eth_ptr, 6'h3F);
      check("R5 still valid", fields_valid, 1);
   endtask

   task automatic t_slave_hs();
      do_reset(1'b0);
      send_hf(8'h01);
      send_hf(8'h00);
      check("R6 single hyperframe no pulse", lr_count, 0);
      check("R7 no ack", tx_reset_bit, 0);
      send_hf(8'h01);
      send_hf(8'h01);
      check("R6 two consecutive pulse once", lr_count, 1);
      check("R7 ack set", tx_reset_bit, 1);
      check("R8 sdi set", tx_sdi_bit, 1);
      check("R8 forward set", fwd_reset_bit, 1);
      send_hf(8'h01);
      check("R6 held bit no retrigger", lr_count, 1);
      repeat (3) send_hf(8'h00);
      check("R7 ack after 4", tx_reset_bit, 1);
      send_hf(8'h00);
      check("R7 ack ends after 5", tx_reset_bit, 0);
      check("R8 forward after 5", fwd_reset_bit, 1);
      repeat (4) send_hf(8'h00);
      check("R8 sdi after 9", tx_sdi_bit, 1);
      send_hf(8'h00);
      check("R8 sdi ends after 10", tx_sdi_bit, 0);
      check("R8 forward ends after 10", fwd_reset_bit, 0);
      check("R10 no ack pulse in slave", ack_count, 0);
   endtask

   task automatic t_master_hs();
      do_reset(1'b1);
      check("R9 idle", tx_reset_bit, 0);
      reset_req = 1'b1;
      @(negedge clk);
      reset_req = 1'b0;
      check("R9 request starts", tx_reset_bit, 1);
      send_hf(8'h00);
      send_hf(8'h00);
      send_hf(8'h01);
      send_hf(8'h01);
      check("R10 ack pulses", ack_count, 2);
      check("R9 no local reset in master", lr_count, 0);
      repeat (5) send_hf(8'h00);
      check("R9 held after 9", tx_reset_bit, 1);
      send_hf(8'h00);
      check("R9 ends after 10", tx_reset_bit, 0);
      check("R9 no sdi in master", tx_sdi_bit, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset_state();
      t_split();
      t_fields();
      t_slave_hs();
      t_master_hs();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule